// File: doc/BRIEF.md
# Banked Data Memory with Display Overlay

This block is the data store of a small controller. Its main part is a byte-wide general-purpose RAM. A single CPU port reads and writes it, and one byte of the address space holds a bank selector. A short run of addresses, the overlay window, can be pointed at a separate display memory instead of the general-purpose RAM.

The redirection happens only when two conditions hold together. The bank selector must hold the display bank value, and the access must be an indirect access made through the second memory pointer. The CPU signals an indirect access with a flag that comes with each access. Direct accesses to the window always reach ordinary RAM.

A display driver reads display memory through its own read-only scan port. This port is combinational and is independent of the CPU port. A driver that scans continuously therefore sees each new byte at once and never holds up the CPU. In every display byte, a set bit lights the matching segment and a clear bit blanks it.

Top module: `dmem_bank_top`

## Requirements
- R1: When reset is asserted, the bank selector clears to 0x00 and the registered read output clears to 0x00. The RAM contents are kept through reset.
- R2: A CPU write to address 0x04 loads the full byte into the bank selector. A CPU read of 0x04 returns the value of the bank selector, whether or not the indirect flag is set.
- R3: An indirect write to an address from 0x40 to 0x52 while the bank selector holds 0x01 goes to display entry (address − 0x40). An indirect read under the same conditions returns that entry. The general-purpose RAM at that address is left untouched.
- R4: While the bank selector holds 0x00, indirect accesses to the window reach general-purpose RAM and leave display memory untouched.
- R5: Direct accesses (indirect flag low) to the window reach general-purpose RAM, even while the bank selector holds 0x01.
- R6: Bank selector values other than 0x00 and 0x01 (for example 0x03) behave as bank 0 for the window.
- R7: The window includes both of its end addresses, 0x40 and 0x52. Addresses 0x3F and 0x53 always reach general-purpose RAM.
- R8: A read returns its data on `cpu_rdata` after the first rising clock edge that follows the request, so it has one cycle of latency. `cpu_rdata` holds its value on any cycle that has no read.
- R9: The scan port returns display entry `scan_idx` combinationally for indexes 0 to 18. It returns 0x00 for indexes 19 to 31.
- R10: A display write appears on the scan port immediately after the clock edge that performs it. This holds even while the scan port is addressing that same entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| cpu_en | input | 1 | The CPU access is valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ind2 | input | 1 | The access is indirect through the second memory pointer |
| cpu_addr | input | 8 | Data address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| scan_idx | input | 5 | Display entry index for the scan port |
| scan_data | output | 8 | Display entry byte, combinational |

## Verification
The bench first writes distinct bytes to the same window address through the display path and through the direct path. It then reads both back. A design that ignored the indirect flag, or that decoded any nonzero bank as the display bank, would return the wrong one of the two bytes.

Both window end addresses and both of their outside neighbours are exercised. An off-by-one decode would either place 0x52 in RAM or corrupt the display through 0x53.

Reads are sampled both before and after the clock edge, and again across cycles that carry writes. This catches a read path that is combinational or that does not hold its value.

A reset in the middle of the run must clear the bank selector while RAM keeps its contents. Scan indexes past the end must read as zero rather than aliasing onto another entry.

// File: rtl/dmem_bank_pkg.sv
package dmem_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 5;
  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 8'h04;
  localparam logic [ADDR_W-1:0] WIN_FIRST     = 8'h40;
  localparam logic [ADDR_W-1:0] WIN_LAST      = 8'h52;
  localparam logic [DATA_W-1:0] DISP_BANK     = 8'h01;

  typedef enum logic [1:0] {
    TGT_GP   = 2'd0,
    TGT_DISP = 2'd1,
    TGT_BANK = 2'd2
  } tgt_e;
endpackage

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_bank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W,
  parameter logic [AW-1:0] BANK_ADDR = BANK_REG_ADDR,
  parameter logic [AW-1:0] WIN_LO = WIN_FIRST,
  parameter logic [AW-1:0] WIN_HI = WIN_LAST,
  parameter logic [DW-1:0] SEL_BANK = DISP_BANK
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic          ind2_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] bank_i,
  output tgt_e          tgt_o,
  output logic [IW-1:0] disp_idx_o,
  output logic          gp_we_o,
  output logic          disp_we_o,
  output logic          bank_we_o
);
  logic          in_win;
  logic [AW-1:0] offs;

  always_comb begin
    in_win = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
    offs   = addr_i - WIN_LO;
    disp_idx_o = offs[IW-1:0];
    if (addr_i == BANK_ADDR)
      tgt_o = TGT_BANK;
    else if (in_win && ind2_i && (bank_i == SEL_BANK))
      tgt_o = TGT_DISP;
    else
      tgt_o = TGT_GP;
    gp_we_o   = en_i && we_i && (tgt_o == TGT_GP);
    disp_we_o = en_i && we_i && (tgt_o == TGT_DISP);
    bank_we_o = en_i && we_i && (tgt_o == TGT_BANK);
  end
endmodule

// File: rtl/dmem_gp_ram.sv
module dmem_gp_ram
  import dmem_bank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/dmem_disp_mem.sv
module dmem_disp_mem
  import dmem_bank_pkg::*;
#(
  parameter int unsigned DEPTH = 19,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic [IW-1:0] scan_idx_i,
  output logic [DW-1:0] scan_data_o
);
  logic [DW-1:0] row [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic hit;
    assign hit = we_i && (widx_i == IW'(g));
    always_ff @(posedge clk) begin
      if (hit) row[g] <= wdata_i;
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    scan_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (widx_i == IW'(i))     cpu_rdata_o = row[i];
      if (scan_idx_i == IW'(i)) scan_data_o = row[i];
    end
  end

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(widx_i) < DEPTH));

  // R10
  scan_sees_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (scan_idx_i != $past(widx_i)) || (scan_data_o == $past(wdata_i)));
endmodule

// File: rtl/dmem_bank_top.sv
module dmem_bank_top
  import dmem_bank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W,
  parameter logic [AW-1:0] BANK_ADDR = BANK_REG_ADDR,
  parameter logic [AW-1:0] WIN_LO = WIN_FIRST,
  parameter logic [AW-1:0] WIN_HI = WIN_LAST,
  parameter logic [DW-1:0] SEL_BANK = DISP_BANK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic          cpu_ind2,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [IW-1:0] scan_idx,
  output logic [DW-1:0] scan_data
);
  localparam int unsigned DEPTH = int'(WIN_HI) - int'(WIN_LO) + 1;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [DW-1:0] bank_q, bank_d;
  logic [DW-1:0] rdata_q, rdata_d;
  tgt_e          tgt;
  logic [IW-1:0] disp_idx;
  logic          gp_we, disp_we, bank_we;
  logic [DW-1:0] gp_rd, disp_rd;
  logic          rd_en;

  dmem_route #(
    .AW(AW), .DW(DW), .IW(IW), .BANK_ADDR(BANK_ADDR),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .SEL_BANK(SEL_BANK)
  ) u_route (
    .en_i(cpu_en), .we_i(cpu_we), .ind2_i(cpu_ind2), .addr_i(cpu_addr),
    .bank_i(bank_q), .tgt_o(tgt), .disp_idx_o(disp_idx),
    .gp_we_o(gp_we), .disp_we_o(disp_we), .bank_we_o(bank_we)
  );

  dmem_gp_ram #(.AW(AW), .DW(DW)) u_gp (
    .clk(clk), .we_i(gp_we), .addr_i(cpu_addr), .wdata_i(cpu_wdata),
    .rdata_o(gp_rd)
  );

  dmem_disp_mem #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_disp (
    .clk(clk), .rst_n(rst_sync), .we_i(disp_we), .widx_i(disp_idx),
    .wdata_i(cpu_wdata), .cpu_rdata_o(disp_rd),
    .scan_idx_i(scan_idx), .scan_data_o(scan_data)
  );

  assign rd_en = cpu_en && !cpu_we;

  always_comb begin
    bank_d  = bank_q;
    rdata_d = rdata_q;
    if (bank_we) bank_d = cpu_wdata;
    if (rd_en) begin
      unique case (tgt)
        TGT_BANK: rdata_d = bank_q;
        TGT_DISP: rdata_d = disp_rd;
        default:  rdata_d = gp_rd;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      bank_q  <= '0;
      rdata_q <= '0;
    end else begin
      bank_q  <= bank_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_rdata = rdata_q;

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    bank_we |=> bank_q == $past(cpu_wdata));

  // R5
  direct_no_disp_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (cpu_en && !cpu_ind2) |-> !disp_we);

  // R6
  disp_needs_bank_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    disp_we |-> (bank_q == SEL_BANK));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !rd_en |=> $stable(cpu_rdata));

  // R3
  disp_write_once_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0({gp_we, disp_we, bank_we}));
endmodule

// File: tb/dmem_bank_top_bench.sv
module dmem_bank_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_en = 1'b0, cpu_we = 1'b0, cpu_ind2 = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0;
  logic [7:0] cpu_rdata, scan_data;
  logic [4:0] scan_idx = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dmem_bank_top u_dmem_bank_top (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we),
    .cpu_ind2(cpu_ind2), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .scan_idx(scan_idx), .scan_data(scan_data)
  );

  // kind: 0 write, 1 read-and-compare, 2 scan-compare
  // fields: kind[22:21] req[20:17] ind[16] addr[15:8] data[7:0]
  localparam int NV = 24;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 4'd2, 1'b0, 8'h04, 8'h01},  // R2 bank := 1
    {2'd1, 4'd2, 1'b1, 8'h04, 8'h01},  // R2 read bank indirect
    {2'd0, 4'd3, 1'b1, 8'h40, 8'hA5},  // R3 display entry 0
    {2'd2, 4'd3, 1'b0, 8'd0,  8'hA5},  // R3
    {2'd1, 4'd3, 1'b1, 8'h40, 8'hA5},  // R3 read back display
    {2'd0, 4'd7, 1'b1, 8'h52, 8'h3C},  // R7 upper end
    {2'd2, 4'd7, 1'b0, 8'd18, 8'h3C},  // R7
    {2'd0, 4'd7, 1'b1, 8'h3F, 8'h11},  // R7 below window
    {2'd0, 4'd7, 1'b1, 8'h53, 8'h22},  // R7 above window
    {2'd0, 4'd5, 1'b0, 8'h40, 8'h77},  // R5 direct write in bank 1
    {2'd1, 4'd5, 1'b0, 8'h40, 8'h77},  // R5
    {2'd2, 4'd5, 1'b0, 8'd0,  8'hA5},  // R5 display untouched
    {2'd1, 4'd3, 1'b1, 8'h40, 8'hA5},  // R3 still display
    {2'd0, 4'd4, 1'b0, 8'h04, 8'h00},  // R4 bank := 0
    {2'd1, 4'd4, 1'b1, 8'h40, 8'h77},  // R4 indirect reaches RAM
    {2'd2, 4'd4, 1'b0, 8'd0,  8'hA5},  // R4
    {2'd0, 4'd6, 1'b0, 8'h04, 8'h03},  // R6 bank := 3
    {2'd1, 4'd6, 1'b1, 8'h40, 8'h77},  // R6
    {2'd0, 4'd6, 1'b1, 8'h40, 8'h99},  // R6 write lands in RAM
    {2'd2, 4'd6, 1'b0, 8'd0,  8'hA5},  // R6 display untouched
    {2'd1, 4'd6, 1'b0, 8'h40, 8'h99},  // R6
    {2'd1, 4'd7, 1'b1, 8'h3F, 8'h11},  // R7
    {2'd1, 4'd7, 1'b1, 8'h53, 8'h22},  // R7
    {2'd2, 4'd9, 1'b0, 8'd19, 8'h00}   // R9 out of range
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input bit ind, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = we; cpu_ind2 = ind; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1", cpu_rdata, 8'h00);
    access(1'b0, 1'b0, 8'h04, 8'h00);
    chk("R1", cpu_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[20:17]);
      case (v[22:21])
        2'd0: access(1'b1, v[16], v[15:8], v[7:0]);
        2'd1: begin
          access(1'b0, v[16], v[15:8], 8'h00);
          chk(rq, cpu_rdata, v[7:0]);
        end
        default: begin
          @(negedge clk);
          scan_idx = v[12:8];
          #1;
          chk(rq, scan_data, v[7:0]);
        end
      endcase
    end

    // R9 top index
    scan_idx = 5'd31; #1;
    chk("R9", scan_data, 8'h00);

    // R8 latency and hold: bank is 3, RAM[0x40]=0x99, RAM[0x3F]=0x11
    access(1'b0, 1'b0, 8'h40, 8'h00);
    chk("R8", cpu_rdata, 8'h99);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_ind2 = 1'b1; cpu_addr = 8'h3F;
    #1;
    chk("R8", cpu_rdata, 8'h99);
    @(negedge clk);
    cpu_en = 1'b0;
    chk("R8", cpu_rdata, 8'h11);
    access(1'b1, 1'b0, 8'h60, 8'h5E);
    chk("R8", cpu_rdata, 8'h11);
    @(negedge clk);
    chk("R8", cpu_rdata, 8'h11);

    // R10 write seen by scan right after the edge
    access(1'b1, 1'b0, 8'h04, 8'h01);
    @(negedge clk);
    scan_idx = 5'd5;
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_ind2 = 1'b1; cpu_addr = 8'h45; cpu_wdata = 8'hC3;
    @(posedge clk);
    #1;
    chk("R10", scan_data, 8'hC3);
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;

    // R1 mid-run reset: bank cleared, RAM kept
    do_reset();
    chk("R1", cpu_rdata, 8'h00);
    access(1'b0, 1'b0, 8'h04, 8'h00);
    chk("R1", cpu_rdata, 8'h00);
    access(1'b0, 1'b1, 8'h40, 8'h00);
    chk("R1", cpu_rdata, 8'h99);
    scan_idx = 5'd0; #1;
    chk("R1", scan_data, 8'hA5);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule